// File: doc/BRIEF.md
# Four-Port GPIO Group with Masked Bit Writes

This block holds four 8-bit general-purpose I/O ports behind one 32-bit register bus. Each port keeps a pin enable, an output-drive enable, an output value, a synchronized copy of its pad inputs, and a set of level-sensitive interrupt registers. The pad-side vectors (input, output value, output enable) of all ports are concatenated, with port p on bits 8p+7:8p. One interrupt line covers the whole group.

The normal register window is laid out by register kind, 0x10 apart, with the four ports interleaved at a 4-byte stride inside each kind. The same offsets with bit 11 set (offset plus 0x800) form a masked-write window. A word written there carries a per-bit select mask in bits 15:8 and new bit values in bits 7:0. Software can therefore set or clear single output pins in one bus write, without reading the register first and without disturbing pins that another agent is changing.

Bus reads are registered: a read request accepted on a clock edge returns its data with `rsp_valid` on the following cycle. Writes take effect on the edge that accepts them.

Top module: `gpio_group`

## Requirements
- R1: After reset every port register is zero, `pad_out` and `pad_oe` are all zero and `irq` is low.
- R2: Register offsets are kind*0x10 + port*4, with kinds 0 pin enable, 1 output enable, 2 output value, 3 input value, 4 interrupt status, 5 interrupt enable, 6 interrupt level, 7 interrupt clear. A read accepted on an edge sets `rsp_valid` for the next cycle, with the byte in bits 7:0 and zeros in bits 31:8.
- R3: A normal-window write to pin enable, output enable, output value, interrupt enable or interrupt level loads `req_wdata[7:0]`. Writes to the input value and interrupt status registers change nothing.
- R4: Per pin, `pad_oe` is high only when both the pin enable and the output enable bits are set, and `pad_out` follows the output value register.
- R5: A write at offset+0x800 to pin enable, output enable or output value changes only the bits selected by `req_wdata[15:8]`, each to the matching bit of `req_wdata[7:0]`. Select bits with zero value bits clear those pins; the same pattern in both bytes sets them. Bits 31:16 are ignored.
- R6: A masked-window write to the interrupt enable, level, clear, input or status registers has no effect.
- R7: Pad inputs pass a two-flop synchronizer. After a pad change, reads accepted on the first and second following edges return the old input value, and reads accepted on the third edge or later return the new value.
- R8: A status bit sets on the edge after its synchronized input equals its interrupt level bit while its interrupt enable bit is set. Level 1 matches a high pin and level 0 a low pin.
- R9: Writing 1 to a bit of the interrupt clear register clears that status bit. If the set condition still holds on the same edge, the bit stays set.
- R10: `irq` is high exactly when some status bit of some port is set with its enable bit set. Clearing an enable bit drops its contribution but leaves the status bit stored.
- R11: Reads through the masked window return the same data as the normal window, and the interrupt clear register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset; bit 11 selects the masked window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad inputs, port p on bits 8p+7:8p |
| pad_out | output | 32 | Output values for the pads |
| pad_oe | output | 32 | Output drive enables for the pads |
| irq | output | 1 | Combined interrupt for the four ports |

## Verification
On every cycle the assertions check the two-cycle synchronizer delay, that each read request gets exactly one response one cycle later, that a status bit never sets unless its enable bit was set, that the pad drive enables move only after a bus write, and that `irq` never rises with an empty status. The address map, the select-mask merges in the masked window, the ignored masked writes, the exact edge on which an interrupt appears, and set taking priority over a clear are shown only by the bench's directed scenarios, which compare read-back values and pad vectors with values worked out from the requirements.

// File: rtl/gpio_group_pkg.sv
package gpio_group_pkg;

    localparam int PIN_W      = 8;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int MAX_PORTS  = 4;
    localparam int PORT_IDX_W = 2;
    localparam int KIND_W     = 3;
    localparam int ALIAS_BIT  = 11;

    typedef enum logic [KIND_W-1:0] {
        K_ENABLE   = 3'd0,
        K_OUT_EN   = 3'd1,
        K_OUT_VAL  = 3'd2,
        K_PIN_IN   = 3'd3,
        K_INT_STAT = 3'd4,
        K_INT_EN   = 3'd5,
        K_INT_LVL  = 3'd6,
        K_INT_CLR  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic                  hit;
        logic                  alias_win;
        logic [PORT_IDX_W-1:0] port;
        reg_kind_e             kind;
    } bus_dec_t;

    typedef struct packed {
        logic             masked;
        reg_kind_e        kind;
        logic [PIN_W-1:0] sel;
        logic [PIN_W-1:0] val;
    } port_wr_t;

    // Offset layout: [11] window, [10:7] zero, [6:4] kind, [3:2] port, [1:0] zero
    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.hit       = (a[10:7] == 4'd0) && (a[1:0] == 2'd0);
        d.alias_win = a[ALIAS_BIT];
        d.port      = a[3:2];
        d.kind      = reg_kind_e'(a[6:4]);
        return d;
    endfunction

    // Plain writes replace the lane; masked writes merge under the select byte.
    function automatic logic [PIN_W-1:0] lane_update(input logic [PIN_W-1:0] cur,
                                                     input port_wr_t w);
        if (w.masked)
            return (cur & ~w.sel) | (w.val & w.sel);
        return w.val;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_group_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  port_wr_t         wr,
    input  logic [PIN_W-1:0] pin_sync,
    output logic [PIN_W-1:0] en_q,
    output logic [PIN_W-1:0] oe_q,
    output logic [PIN_W-1:0] out_q,
    output logic [PIN_W-1:0] ien_q,
    output logic [PIN_W-1:0] lvl_q,
    output logic [PIN_W-1:0] stat_q
);
    logic [PIN_W-1:0] en_d, oe_d, out_d, ien_d, lvl_d, stat_d;
    logic [PIN_W-1:0] clr_bits, hit_bits;

    always_comb begin
        en_d     = en_q;
        oe_d     = oe_q;
        out_d    = out_q;
        ien_d    = ien_q;
        lvl_d    = lvl_q;
        clr_bits = '0;
        if (wr_en) begin
            case (wr.kind)
                K_ENABLE:  en_d  = lane_update(en_q, wr);
                K_OUT_EN:  oe_d  = lane_update(oe_q, wr);
                K_OUT_VAL: out_d = lane_update(out_q, wr);
                K_INT_EN:  if (!wr.masked) ien_d = wr.val;
                K_INT_LVL: if (!wr.masked) lvl_d = wr.val;
                K_INT_CLR: if (!wr.masked) clr_bits = wr.val;
                default:   ;
            endcase
        end
        // Level match on enabled pins; a live match outranks a clear.
        hit_bits = ien_q & ~(pin_sync ^ lvl_q);
        stat_d   = (stat_q & ~clr_bits) | hit_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            oe_q   <= '0;
            out_q  <= '0;
            ien_q  <= '0;
            lvl_q  <= '0;
            stat_q <= '0;
        end else begin
            en_q   <= en_d;
            oe_q   <= oe_d;
            out_q  <= out_d;
            ien_q  <= ien_d;
            lvl_q  <= lvl_d;
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_group_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int BUS_W    = NUM_PORTS * PIN_W
) (
    input  bus_dec_t         dec,
    input  logic [BUS_W-1:0] en_flat,
    input  logic [BUS_W-1:0] oe_flat,
    input  logic [BUS_W-1:0] out_flat,
    input  logic [BUS_W-1:0] sync_flat,
    input  logic [BUS_W-1:0] status_flat,
    input  logic [BUS_W-1:0] inten_flat,
    input  logic [BUS_W-1:0] level_flat,
    output logic [PIN_W-1:0] rd_byte
);
    int idx;

    always_comb begin
        idx     = int'(dec.port);
        rd_byte = '0;
        if (dec.hit && idx < NUM_PORTS) begin
            case (dec.kind)
                K_ENABLE:   rd_byte = en_flat[idx*PIN_W +: PIN_W];
                K_OUT_EN:   rd_byte = oe_flat[idx*PIN_W +: PIN_W];
                K_OUT_VAL:  rd_byte = out_flat[idx*PIN_W +: PIN_W];
                K_PIN_IN:   rd_byte = sync_flat[idx*PIN_W +: PIN_W];
                K_INT_STAT: rd_byte = status_flat[idx*PIN_W +: PIN_W];
                K_INT_EN:   rd_byte = inten_flat[idx*PIN_W +: PIN_W];
                K_INT_LVL:  rd_byte = level_flat[idx*PIN_W +: PIN_W];
                default:    rd_byte = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_group.sv
module gpio_group
    import gpio_group_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int BUS_W    = NUM_PORTS * PIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [BUS_W-1:0]  pad_in,
    output logic [BUS_W-1:0]  pad_out,
    output logic [BUS_W-1:0]  pad_oe,
    output logic              irq
);
    bus_dec_t         dec;
    port_wr_t         wr;
    logic             rd_req;
    logic [PIN_W-1:0] rd_byte;

    logic [BUS_W-1:0] sync_flat, en_flat, oe_flat, out_flat;
    logic [BUS_W-1:0] status_flat, inten_flat, level_flat;

    assign dec    = decode_addr(req_addr);
    assign rd_req = req_valid && !req_write;

    always_comb begin
        wr.masked = dec.alias_win;
        wr.kind   = dec.kind;
        wr.sel    = req_wdata[2*PIN_W-1:PIN_W];
        wr.val    = req_wdata[PIN_W-1:0];
    end

    gpio_sync #(.W(BUS_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_flat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_sel;
        assign wr_sel = req_valid && req_write && dec.hit &&
                        (dec.port == PORT_IDX_W'(p));

        gpio_port u_port (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_sel),
            .wr       (wr),
            .pin_sync (sync_flat[p*PIN_W +: PIN_W]),
            .en_q     (en_flat[p*PIN_W +: PIN_W]),
            .oe_q     (oe_flat[p*PIN_W +: PIN_W]),
            .out_q    (out_flat[p*PIN_W +: PIN_W]),
            .ien_q    (inten_flat[p*PIN_W +: PIN_W]),
            .lvl_q    (level_flat[p*PIN_W +: PIN_W]),
            .stat_q   (status_flat[p*PIN_W +: PIN_W])
        );
    end

    assign pad_out = out_flat;
    assign pad_oe  = en_flat & oe_flat;
    assign irq     = |(status_flat & inten_flat);

    gpio_readback #(.NUM_PORTS(NUM_PORTS)) u_rb (
        .dec         (dec),
        .en_flat     (en_flat),
        .oe_flat     (oe_flat),
        .out_flat    (out_flat),
        .sync_flat   (sync_flat),
        .status_flat (status_flat),
        .inten_flat  (inten_flat),
        .level_flat  (level_flat),
        .rd_byte     (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req)
                rsp_rdata <= {{(DATA_W-PIN_W){1'b0}}, rd_byte};
        end
    end
endmodule

// File: rtl/gpio_group_checker.sv
module gpio_group_checker
    import gpio_group_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int BUS_W    = NUM_PORTS * PIN_W
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic [BUS_W-1:0] pad_in,
    input logic [BUS_W-1:0] pad_oe,
    input logic             irq,
    input logic [BUS_W-1:0] sync_flat,
    input logic [BUS_W-1:0] status_flat,
    input logic [BUS_W-1:0] inten_flat
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!irq && pad_oe == '0));

    p_read_answer_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    p_answer_has_req_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    p_oe_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid && req_write) |-> $stable(pad_oe));

    p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2)) |-> (sync_flat == $past(pad_in, 2)));

    p_set_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        ((status_flat & ~$past(status_flat)) & ~$past(inten_flat)) == '0);

    p_irq_has_source_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_flat != '0));
endmodule

bind gpio_group gpio_group_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .irq         (irq),
    .sync_flat   (sync_flat),
    .status_flat (status_flat),
    .inten_flat  (inten_flat)
);

// File: tb/gpio_group_test.sv
module gpio_group_test;
    localparam int KE = 0, KO = 1, KV = 2, KI = 3, KS = 4, KN = 5, KL = 6, KC = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_group uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [11:0] ofs(input int kind, input int port, input bit alias_win);
        return 12'((alias_win ? 'h800 : 0) + kind * 16 + port * 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic t_reset_r1();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        for (int p = 0; p < 4; p++) begin
            bus_rd(ofs(KV, p, 0), d);
            check("R1 out reg", d, 32'h0);
        end
        bus_rd(ofs(KL, 3, 0), d);
        check("R1 level reg", d, 32'h0);
    endtask

    task automatic t_map_r2_r3();
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            bus_wr(ofs(KV, p, 0), 32'(8'hA0 + p));
            bus_wr(ofs(KE, p, 0), 32'(8'h10 + p));
        end
        for (int p = 0; p < 4; p++) begin
            bus_rd(ofs(KV, p, 0), d);
            check("R2 out map", d, 32'(8'hA0 + p));
            check("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
            bus_rd(ofs(KE, p, 0), d);
            check("R2 enable map", d, 32'(8'h10 + p));
        end
        bus_wr(ofs(KL, 2, 0), 32'hFFFF_FF5A);
        bus_rd(ofs(KL, 2, 0), d);
        check("R3 level loads low byte", d, 32'h0000_005A);
        check("R4 pad_out", pad_out, 32'hA3A2_A1A0);
        bus_wr(ofs(KI, 1, 0), 32'hFF);
        bus_wr(ofs(KS, 1, 0), 32'hFF);
        bus_rd(ofs(KI, 1, 0), d);
        check("R3 input write ignored", d, 32'h0);
        bus_rd(ofs(KS, 1, 0), d);
        check("R3 status write ignored", d, 32'h0);
    endtask

    task automatic t_pads_r4();
        bus_wr(ofs(KE, 3, 0), 32'h0F);
        bus_wr(ofs(KO, 3, 0), 32'hFF);
        check("R4 pad_oe gated by enable", pad_oe, 32'h0F00_0000);
    endtask

    task automatic t_masked_r5();
        logic [31:0] d;
        bus_wr(ofs(KV, 0, 1), 32'hFFFF_0C04);
        check("R5 merge", {24'b0, pad_out[7:0]}, 32'hA4);
        bus_wr(ofs(KV, 0, 1), 32'h0000_8000);
        check("R5 clear pattern", {24'b0, pad_out[7:0]}, 32'h24);
        bus_wr(ofs(KV, 0, 1), 32'h0000_0303);
        check("R5 set pattern", {24'b0, pad_out[7:0]}, 32'h27);
        check("R5 other ports untouched", pad_out, 32'hA3A2_A127);
        bus_rd(ofs(KV, 0, 0), d);
        check("R5 readback", d, 32'h27);
        bus_wr(ofs(KO, 3, 1), 32'hABCD_0F00);
        check("R5 masked oe", pad_oe, 32'h0);
        bus_rd(ofs(KO, 3, 0), d);
        check("R5 oe readback", d, 32'hF0);
    endtask

    task automatic t_masked_ignored_r6();
        logic [31:0] d;
        bus_wr(ofs(KL, 1, 1), 32'h0000_FFFF);
        bus_wr(ofs(KN, 1, 1), 32'h0000_FFFF);
        bus_rd(ofs(KL, 1, 0), d);
        check("R6 level unchanged", d, 32'h0);
        bus_rd(ofs(KN, 1, 0), d);
        check("R6 inten unchanged", d, 32'h0);
        check("R6 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sync_r7();
        logic [31:0] d;
        pad_in[23:16] = 8'h5A;
        bus_rd(ofs(KI, 2, 0), d);
        check("R7 first edge old", d, 32'h0);
        bus_rd(ofs(KI, 2, 0), d);
        check("R7 second edge old", d, 32'h0);
        bus_rd(ofs(KI, 2, 0), d);
        check("R7 third edge new", d, 32'h5A);
    endtask

    task automatic t_irq_r8_r10();
        logic [31:0] d;
        bus_wr(ofs(KL, 2, 0), 32'hFF);
        bus_wr(ofs(KN, 2, 0), 32'h01);
        @(negedge clk);
        check("R8 no match no irq", {31'b0, irq}, 32'h0);
        pad_in[16] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq on third edge", {31'b0, irq}, 32'h1);
        bus_rd(ofs(KS, 2, 0), d);
        check("R8 status bit", d, 32'h01);
        bus_wr(ofs(KN, 2, 0), 32'h00);
        check("R10 disable drops irq", {31'b0, irq}, 32'h0);
        bus_rd(ofs(KS, 2, 0), d);
        check("R10 status kept", d, 32'h01);
        bus_wr(ofs(KN, 2, 0), 32'h01);
        check("R10 re-enable irq", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear_r9();
        logic [31:0] d;
        bus_wr(ofs(KC, 2, 0), 32'h01);
        bus_rd(ofs(KS, 2, 0), d);
        check("R9 set beats clear", d, 32'h01);
        pad_in[16] = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr(ofs(KC, 2, 0), 32'h01);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
        bus_rd(ofs(KS, 2, 0), d);
        check("R9 status cleared", d, 32'h0);
    endtask

    task automatic t_low_level_r8();
        bus_wr(ofs(KN, 3, 0), 32'h80);
        check("R8 level0 one edge later", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 level0 match irq", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_alias_read_r11();
        logic [31:0] d;
        bus_rd(ofs(KV, 0, 1), d);
        check("R11 alias read", d, 32'h27);
        bus_rd(ofs(KC, 3, 0), d);
        check("R11 clear reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_map_r2_r3();
        t_pads_r4();
        t_masked_r5();
        t_masked_ignored_r6();
        t_sync_r7();
        t_irq_r8_r10();
        t_clear_r9();
        t_low_level_r8();
        t_alias_read_r11();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule